// File: doc/BRIEF.md
# Tap-Selectable Noise Shift-Register Generator

This block is the pseudorandom source of a noise sound channel. A 15-bit shift register advances once per step period. On each step a fresh bit enters at the bottom. That bit is the inverted XOR of register bit 7 and one further register bit, which a 3-bit tap selector picks. The step period is forty times the period of an ordinary wave channel at the same 11-bit frequency setting. That makes it `40 × (2048 − frequency)` clocks.

The channel output is a 6-bit sample. It is full scale (63) while register bit 0 is set and zero otherwise. It is forced to zero whenever the channel enable is low. Software-side logic drives the tap selector, a tap-write strobe, a channel-start strobe, the frequency and the enable. The envelope, the stereo levels and the output filtering sit outside this block.

Top module: `noise_lfsr_gen`

## Requirements
- R1: Tap selector values 0, 1, 2, 3, 4, 5, 6, 7 choose register bit 14, 10, 13, 4, 8, 6, 9, 11 respectively as the variable feedback tap.
- R2: The bit inserted on a step equals NOT(selected tap bit XOR register bit 7); from an all-zero register the first inserted bit is therefore 1.
- R3: On a step the register becomes {old bits 13..0, new bit}; old bit 14 is discarded, and the register holds its value in every cycle that has neither a step nor a clear.
- R4: After a channel start, steps occur on exactly every P-th enabled clock edge, where P = 40 × (2048 − frequency); the output does not change in the P−1 enabled edges between steps.
- R5: sample_o is 63 when register bit 0 is 1 and 0 when it is 0; no other value ever appears.
- R6: While enable_i is low, sample_o is 0, and neither the period counter nor the register advances; raising enable_i resumes the count where it stopped.
- R7: A tap-write strobe stores the new selector and clears the register to zero without disturbing the period counter, so the next step still falls at its scheduled edge.
- R8: A channel-start strobe clears the register and reloads the period counter with P computed from the frequency present at that edge; a start also takes precedence over a step in the same cycle.
- R9: The frequency is read only when the counter reloads (at a start or at a step), so a frequency change mid-period takes effect from the following period.
- R10: After reset the register, the tap selector and the period counter are zero, so the first enabled clock edge performs a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_sel_i | input | 3 | Feedback tap selector, stored on tap_wr_i |
| tap_wr_i | input | 1 | Tap-write strobe; also clears the register |
| start_i | input | 1 | Channel-start strobe; clears register, reloads period |
| freq_i | input | 11 | Frequency setting |
| enable_i | input | 1 | Channel enable |
| sample_o | output | 6 | Noise sample, 0 or 63 |

## Verification
Every one of the eight tap settings runs for forty steps at two different periods, 40 and 80 clocks. The sequence of sample values then separates a wrong tap position, a missing inversion or a bad shift, and the hold check one edge before each step catches an off-by-one period. A long period of 320 clocks confirms that the multiplier scales with the frequency. Directed runs pause the enable mid-period, change the frequency mid-period, write the tap mid-run, and restart with a new frequency. These runs show that the count freezes rather than resets, that the frequency is latched only at reload, that a tap write leaves the schedule alone, and that a start reloads it.

// File: rtl/noise_lfsr_pkg.sv
package noise_lfsr_pkg;

    localparam int NL_LFSR_W    = 15;
    localparam int NL_FREQ_W    = 11;
    localparam int NL_TAP_W     = 3;
    localparam int NL_SAMPLE_W  = 6;
    localparam int NL_STEP_MULT = 40;
    localparam int NL_FIXED_TAP = 7;

    // Control decoded for the shift register each cycle
    typedef struct packed {
        logic clear;
        logic step;
    } shift_ctl_t;

    // Selector to variable feedback position
    function automatic int tap_position(input logic [NL_TAP_W-1:0] sel);
        case (sel)
            3'd0:    return 14;
            3'd1:    return 10;
            3'd2:    return 13;
            3'd3:    return 4;
            3'd4:    return 8;
            3'd5:    return 6;
            3'd6:    return 9;
            default: return 11;
        endcase
    endfunction

    // Clocks between steps for a frequency setting
    function automatic int unsigned period_clocks(input int unsigned freq,
                                                  input int unsigned freq_w,
                                                  input int unsigned mult);
        return mult * ((32'd1 << freq_w) - freq);
    endfunction

endpackage

// File: rtl/noise_period_timer.sv
module noise_period_timer
    import noise_lfsr_pkg::*;
#(
    parameter int FREQ_W    = NL_FREQ_W,
    parameter int STEP_MULT = NL_STEP_MULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] freq_i,
    output logic              step_o
);
    localparam int unsigned MAX_PERIOD = STEP_MULT * (2 ** FREQ_W);
    localparam int          CNT_W      = $clog2(MAX_PERIOD + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;
    logic             expire;

    assign reload = CNT_W'(period_clocks(32'(freq_i), FREQ_W, STEP_MULT));
    assign expire = (cnt_q <= CNT_W'(1));
    assign step_o = enable_i && !start_i && expire;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= reload;
        end else if (enable_i) begin
            if (expire) cnt_q <= reload;
            else        cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // R6: count frozen while disabled and not restarted
    assert_count_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (!enable_i && !start_i) |=> $stable(cnt_q));

    // R4: counter never holds more than one full period
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(MAX_PERIOD));

    // R8: counter is nonzero right after a start
    assert_start_loads_R8: assert property (@(posedge clk) disable iff (rst)
        start_i |=> cnt_q != '0);

endmodule

// File: rtl/noise_shift_reg.sv
module noise_shift_reg
    import noise_lfsr_pkg::*;
#(
    parameter int LFSR_W    = NL_LFSR_W,
    parameter int TAP_W     = NL_TAP_W,
    parameter int FIXED_TAP = NL_FIXED_TAP
) (
    input  logic              clk,
    input  logic              rst,
    input  shift_ctl_t        ctl_i,
    input  logic [TAP_W-1:0]  tap_sel_i,
    output logic [LFSR_W-1:0] state_o
);
    localparam int IDX_W = $clog2(LFSR_W);

    logic [LFSR_W-1:0] state_q;
    logic [IDX_W-1:0]  tap_idx;
    logic              fresh_bit;

    assign tap_idx   = IDX_W'(tap_position(tap_sel_i));
    assign fresh_bit = ~(state_q[tap_idx] ^ state_q[FIXED_TAP]);
    assign state_o   = state_q;

    always_ff @(posedge clk) begin
        if (rst || ctl_i.clear) begin
            state_q <= '0;
        end else if (ctl_i.step) begin
            state_q <= {state_q[LFSR_W-2:0], fresh_bit};
        end
    end

    // R7 / R8: a clear empties the register
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
        ctl_i.clear |=> state_q == '0);

    // R3: without step or clear the register holds
    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.clear && !ctl_i.step) |=> $stable(state_q));

    // R3: a step moves the low bits up by one place
    assert_shift_up_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.step && !ctl_i.clear) |=>
            state_q[LFSR_W-1:1] == $past(state_q[LFSR_W-2:0]));

endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
    import noise_lfsr_pkg::*;
#(
    parameter int LFSR_W    = NL_LFSR_W,
    parameter int FREQ_W    = NL_FREQ_W,
    parameter int TAP_W     = NL_TAP_W,
    parameter int SAMPLE_W  = NL_SAMPLE_W,
    parameter int STEP_MULT = NL_STEP_MULT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [TAP_W-1:0]    tap_sel_i,
    input  logic                tap_wr_i,
    input  logic                start_i,
    input  logic [FREQ_W-1:0]   freq_i,
    input  logic                enable_i,
    output logic [SAMPLE_W-1:0] sample_o
);
    localparam logic [SAMPLE_W-1:0] FULL_SCALE = '1;

    logic [TAP_W-1:0]  tap_q;
    logic              step;
    logic [LFSR_W-1:0] state;
    shift_ctl_t        ctl;

    always_ff @(posedge clk) begin
        if (rst)           tap_q <= '0;
        else if (tap_wr_i) tap_q <= tap_sel_i;
    end

    noise_period_timer #(
        .FREQ_W    (FREQ_W),
        .STEP_MULT (STEP_MULT)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .enable_i (enable_i),
        .start_i  (start_i),
        .freq_i   (freq_i),
        .step_o   (step)
    );

    always_comb begin
        ctl.clear = tap_wr_i || start_i;
        ctl.step  = step;
    end

    noise_shift_reg #(
        .LFSR_W    (LFSR_W),
        .TAP_W     (TAP_W),
        .FIXED_TAP (NL_FIXED_TAP)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .ctl_i     (ctl),
        .tap_sel_i (tap_q),
        .state_o   (state)
    );

    assign sample_o = (enable_i && state[0]) ? FULL_SCALE : '0;

    // R6: disabled channel is silent
    assert_silent_off_R6: assert property (@(posedge clk) disable iff (rst)
        !enable_i |-> sample_o == '0);

    // R5: only two output levels
    assert_two_levels_R5: assert property (@(posedge clk) disable iff (rst)
        (sample_o == '0) || (sample_o == FULL_SCALE));

    // R7: tap selector changes only on a tap write
    assert_tap_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !tap_wr_i |=> $stable(tap_q));

    // R8: start has precedence over a step in the same cycle
    assert_start_wins_R8: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !step);

endmodule

// File: tb/noise_lfsr_gen_tb.sv
module noise_lfsr_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  tap_sel = '0;
    logic        tap_wr = 1'b0;
    logic        start = 1'b0;
    logic [10:0] freq = 11'd2047;
    logic        en = 1'b0;
    logic [5:0]  sample;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [14:0] m;   // bench model of the register

    always #(CLK_PERIOD/2) clk = ~clk;

    noise_lfsr_gen u_dut (
        .clk       (clk),
        .rst       (rst),
        .tap_sel_i (tap_sel),
        .tap_wr_i  (tap_wr),
        .start_i   (start),
        .freq_i    (freq),
        .enable_i  (en),
        .sample_o  (sample)
    );

    function automatic int pos_of(input logic [2:0] t);
        int p[8] = '{14, 10, 13, 4, 8, 6, 9, 11};
        return p[t];
    endfunction

    function automatic logic [14:0] adv(input logic [14:0] r, input logic [2:0] t);
        logic nb;
        nb = ~(r[pos_of(t)] ^ r[7]);
        return {r[13:0], nb};
    endfunction

    function automatic logic [5:0] lvl(input logic [14:0] r);
        return r[0] ? 6'd63 : 6'd0;
    endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: sample actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_tap(input logic [2:0] t);
        @(negedge clk); tap_sel = t; tap_wr = 1'b1;
        @(negedge clk); tap_wr = 1'b0;
        m = '0;
    endtask

    task automatic start_ch();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        m = '0;
    endtask

    // Expects to be called just after a start or a step edge
    task automatic run_steps(input logic [2:0] t, input int p, input int n);
        for (int k = 0; k < n; k++) begin
            repeat (p - 1) @(negedge clk);
            check("R4 hold before step", sample, lvl(m));
            @(negedge clk);
            m = adv(m, t);
            check("R1 R2 R3 R5 step value", sample, lvl(m));
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset silent", sample, 6'd0);
        en = 1'b1;
        @(negedge clk);
        check("R10 first enabled edge steps, R2 first bit is 1", sample, 6'd63);
        en = 1'b0;
        @(negedge clk);
        check("R6 disable silences", sample, 6'd0);
        en = 1'b1;

        // Sweep all taps at two periods
        for (int t = 0; t < 8; t++) begin
            for (int f = 0; f < 2; f++) begin
                freq = (f == 0) ? 11'd2047 : 11'd2046;
                write_tap(3'(t));
                start_ch();
                check("R8 start clears", sample, 6'd0);
                run_steps(3'(t), (f == 0) ? 40 : 80, 40);
            end
        end

        // Long period
        freq = 11'd2040;
        write_tap(3'd3);
        start_ch();
        run_steps(3'd3, 320, 10);

        // R6: pause mid-period
        freq = 11'd2047;
        write_tap(3'd0);
        start_ch();
        run_steps(3'd0, 40, 3);
        repeat (10) @(negedge clk);
        en = 1'b0;
        repeat (50) @(negedge clk);
        check("R6 silent while paused", sample, 6'd0);
        en = 1'b1;
        @(negedge clk);
        check("R6 resumes with held value", sample, lvl(m));
        repeat (28) @(negedge clk);
        check("R6 count resumed, no early step", sample, lvl(m));
        @(negedge clk);
        m = adv(m, 3'd0);
        check("R6 step after resumed count", sample, lvl(m));
        run_steps(3'd0, 40, 5);

        // R9: frequency change mid-period
        write_tap(3'd1);
        start_ch();
        repeat (5) @(negedge clk);
        freq = 11'd2046;
        repeat (34) @(negedge clk);
        check("R9 old period still running", sample, lvl(m));
        @(negedge clk);
        m = adv(m, 3'd1);
        check("R9 step at old period", sample, lvl(m));
        run_steps(3'd1, 80, 4);

        // R7: tap write mid-run keeps schedule
        freq = 11'd2047;
        write_tap(3'd2);
        start_ch();
        run_steps(3'd2, 40, 5);
        repeat (10) @(negedge clk);
        @(negedge clk); tap_sel = 3'd5; tap_wr = 1'b1;
        @(negedge clk); tap_wr = 1'b0;
        m = '0;
        check("R7 tap write clears register", sample, 6'd0);
        repeat (27) @(negedge clk);
        check("R7 no early step after tap write", sample, 6'd0);
        @(negedge clk);
        m = adv(m, 3'd5);
        check("R7 step on original schedule", sample, lvl(m));
        run_steps(3'd5, 40, 20);

        // R8: restart mid-period with new frequency
        repeat (15) @(negedge clk);
        freq = 11'd2044;
        start_ch();
        check("R8 restart clears", sample, 6'd0);
        run_steps(3'd5, 160, 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule